// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog Timer

This block is a memory-mapped watchdog with a free-running timebase counter. Software arms it through two enable bits that sit in two separate control registers. Once armed, an internal expiry counter measures windows of 2^N clock cycles. If a first window passes with no service, a warning flag is set and the interrupt output rises. If a second window passes with no service, the system reset request output is asserted and a sticky reset-cause flag is latched. Software services the watchdog by writing ones to the flag bits. This clears the flags and starts a fresh window.

The state machine has four states. `ST_IDLE` means disarmed. `ST_ARMED` is the first window. `ST_WARNED` is the second window, with the interrupt pending. `ST_FIRED` means the reset request is active. The transitions are as follows:
- idle→armed when either enable bit is set.
- armed→warned when the first window ends.
- warned→fired when the second window ends.
- armed/warned/fired→armed on a service write.
- any state→idle when both enable bits are clear.

The reset-cause flag is cleared only by a separate power-on reset input or by a write of one. It therefore survives the system reset that the block itself requests. A build-time option makes the enable bits impossible to clear once the watchdog has started.

The bus port is a plain single-cycle write/read strobe interface. Read data is registered and appears one cycle after the read strobe.

Top module: `twd_watchdog`

## Requirements
- R1: After `rst_n` and `por_n` are both applied, the interrupt and reset request outputs are low, and words 0x0 and 0x4 read as zero.
- R2: The byte offsets are decoded from address bits [3:2] as follows. 0x0 is control word A: bit 3 is the reset-cause flag, bit 2 is the warning flag and bit 1 is enable A. 0x4 is control word B: bit 0 is enable B. 0x8 is the timebase. 0xC reads as zero. Read data is valid on the clock edge that samples `bus_rd_en`.
- R3: The timebase increases by exactly one on every clock edge out of reset, whether the watchdog is armed or not.
- R4: The watchdog runs while either enable bit is 1. A write that clears only one of the two bits leaves the expiry timing undisturbed. With both bits 0 the block disarms and no reset is requested.
- R5: Arming happens on the edge after the enable write (edge W). The warning flag and `irq_o` rise on edge W+1+2^N, and not earlier.
- R6: With no service, `sys_rst_o` and the reset-cause flag rise on edge W+1+2^(N+1). `sys_rst_o` then stays high until a service write or disarm.
- R7: A write to word 0x0 with bit 2 or bit 3 set is a service. Bit 2 clears the warning flag and bit 3 clears the reset-cause flag, each independently. A service restarts the window so that the next warning rises 2^N edges after the service edge. A service on the same edge as an expiry wins over the expiry.
- R8: `irq_o` is high only while the warning flag is set and the watchdog is enabled. Disarming drops `irq_o` at once, while the flag stays readable.
- R9: The reset-cause flag is unaffected by `rst_n` and is cleared by `por_n`.
- R10: With `ENABLE_ONCE`=1, writes of zero to the enable bits have no effect once they are set, so expiry and reset proceed.
- R11: Disarming clears the expiry count, so re-arming starts a full 2^N window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of everything except the reset-cause flag |
| por_n | input | 1 | Active-low asynchronous power-on reset of the reset-cause flag |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Registered read data |
| irq_o | output | 1 | Warning interrupt |
| sys_rst_o | output | 1 | System reset request |

## Verification
The hardest case to reach from the ports is a service write that lands on the very edge where the second window would end and the reset would fire. This case exercises the priority of service over expiry. The bench sweeps the phase of a single service write over every edge from arming up to and including that edge. At each phase it checks the interrupt and reset outputs, and then checks that the next warning rises exactly 2^N edges later. A second instance with the sticky enable option shares the bus, so a stop sequence can be applied to both instances at once and their outputs compared.

// File: rtl/twd_pkg.sv
package twd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_WARNED = 2'd2,
        ST_FIRED  = 2'd3
    } twd_state_e;

    // word selects (byte address bits [3:2])
    localparam int unsigned SEL_CTLA = 0;
    localparam int unsigned SEL_CTLB = 1;
    localparam int unsigned SEL_TB   = 2;

    // field positions
    localparam int unsigned CTLA_CAUSE_BIT = 3;
    localparam int unsigned CTLA_WARN_BIT  = 2;
    localparam int unsigned CTLA_ENA_BIT   = 1;
    localparam int unsigned CTLB_ENB_BIT   = 0;
endpackage

// File: rtl/twd_timebase.sv
module twd_timebase #(
    parameter int unsigned TB_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TB_W-1:0] count_o
);
    logic [TB_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + TB_W'(1);
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/twd_regs.sv
module twd_regs
    import twd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned REG_W       = 32,
    parameter int unsigned TB_W        = 32,
    parameter bit          ENABLE_ONCE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [TB_W-1:0]   tb_i,
    input  logic              first_exp_i,
    input  logic              second_exp_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              en_any_o,
    output logic              service_o,
    output logic              warn_flag_o,
    output logic              cause_flag_o
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              hit_a, hit_b, hit_tb;
    logic              wr_a, wr_b;
    logic              en_a_q, en_b_q, en_a_d, en_b_d;
    logic              warn_q, cause_q;
    logic [REG_W-1:0]  rd_mux, rdata_q;
    logic              unused_bits;

    assign word   = addr[ADDR_W-1:2];
    assign hit_a  = (word == WORD_W'(SEL_CTLA));
    assign hit_b  = (word == WORD_W'(SEL_CTLB));
    assign hit_tb = (word == WORD_W'(SEL_TB));
    assign wr_a   = wr_en && hit_a;
    assign wr_b   = wr_en && hit_b;

    assign unused_bits = ^{addr[1:0], wdata[REG_W-1:CTLA_CAUSE_BIT+1]};

    // enable next-state: sticky variant selected by parameter
    generate
        if (ENABLE_ONCE) begin : g_sticky
            always_comb begin
                en_a_d = en_a_q;
                en_b_d = en_b_q;
                if (wr_a) en_a_d = wdata[CTLA_ENA_BIT] | en_a_q;
                if (wr_b) en_b_d = wdata[CTLB_ENB_BIT] | en_b_q;
            end
        end else begin : g_plain
            always_comb begin
                en_a_d = en_a_q;
                en_b_d = en_b_q;
                if (wr_a) en_a_d = wdata[CTLA_ENA_BIT];
                if (wr_b) en_b_d = wdata[CTLB_ENB_BIT];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_a_q <= 1'b0;
            en_b_q <= 1'b0;
        end else begin
            en_a_q <= en_a_d;
            en_b_q <= en_b_d;
        end
    end

    // warning flag: write-one-to-clear, set by the first expiry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warn_q <= 1'b0;
        end else if (wr_a && wdata[CTLA_WARN_BIT]) begin
            warn_q <= 1'b0;
        end else if (first_exp_i) begin
            warn_q <= 1'b1;
        end
    end

    // reset-cause flag: only power-on reset or write-one clears it
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause_q <= 1'b0;
        end else if (wr_a && wdata[CTLA_CAUSE_BIT]) begin
            cause_q <= 1'b0;
        end else if (second_exp_i) begin
            cause_q <= 1'b1;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_a) begin
            rd_mux[CTLA_CAUSE_BIT] = cause_q;
            rd_mux[CTLA_WARN_BIT]  = warn_q;
            rd_mux[CTLA_ENA_BIT]   = en_a_q;
        end else if (hit_b) begin
            rd_mux[CTLB_ENB_BIT] = en_b_q;
        end else if (hit_tb) begin
            rd_mux[TB_W-1:0] = tb_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_mux;
        end
    end

    assign rdata_o      = rdata_q;
    assign en_any_o     = en_a_q | en_b_q;
    assign service_o    = wr_a && (wdata[CTLA_WARN_BIT] || wdata[CTLA_CAUSE_BIT]);
    assign warn_flag_o  = warn_q;
    assign cause_flag_o = cause_q;
endmodule

// File: rtl/twd_fsm.sv
module twd_fsm
    import twd_pkg::*;
#(
    parameter int unsigned INTERVAL_N = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_any_i,
    input  logic       service_i,
    output twd_state_e state_o,
    output logic       first_exp_o,
    output logic       second_exp_o,
    output logic       sys_rst_o
);
    localparam logic [INTERVAL_N-1:0] CNT_LAST = '1;

    twd_state_e            state_q, state_d;
    logic [INTERVAL_N-1:0] cnt_q;
    logic                  wrap;

    assign wrap = (cnt_q == CNT_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_any_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!en_any_i)      state_d = ST_IDLE;
                else if (service_i) state_d = ST_ARMED;
                else if (wrap)      state_d = ST_WARNED;
            end
            ST_WARNED: begin
                if (!en_any_i)      state_d = ST_IDLE;
                else if (service_i) state_d = ST_ARMED;
                else if (wrap)      state_d = ST_FIRED;
            end
            ST_FIRED: begin
                if (!en_any_i)      state_d = ST_IDLE;
                else if (service_i) state_d = ST_ARMED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // expiry counter: cleared on any state change, service, idle or fired
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if ((state_d != state_q) || service_i ||
                     (state_q == ST_IDLE) || (state_q == ST_FIRED)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + INTERVAL_N'(1);
        end
    end

    // outputs
    always_comb begin
        first_exp_o  = (state_q == ST_ARMED)  && (state_d == ST_WARNED);
        second_exp_o = (state_q == ST_WARNED) && (state_d == ST_FIRED);
        sys_rst_o    = (state_q == ST_FIRED);
    end

    assign state_o = state_q;
endmodule

// File: rtl/twd_watchdog.sv
module twd_watchdog
    import twd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned REG_W       = 32,
    parameter int unsigned TB_W        = 32,
    parameter int unsigned INTERVAL_N  = 16,
    parameter bit          ENABLE_ONCE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);
    logic [TB_W-1:0] tb_count;
    logic            en_any, service, warn_flag, cause_flag;
    logic            first_exp, second_exp;
    twd_state_e      state;

    twd_timebase #(.TB_W(TB_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (tb_count)
    );

    twd_regs #(
        .ADDR_W      (ADDR_W),
        .REG_W       (REG_W),
        .TB_W        (TB_W),
        .ENABLE_ONCE (ENABLE_ONCE)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .por_n        (por_n),
        .wr_en        (bus_wr_en),
        .rd_en        (bus_rd_en),
        .addr         (bus_addr),
        .wdata        (bus_wdata),
        .tb_i         (tb_count),
        .first_exp_i  (first_exp),
        .second_exp_i (second_exp),
        .rdata_o      (bus_rdata),
        .en_any_o     (en_any),
        .service_o    (service),
        .warn_flag_o  (warn_flag),
        .cause_flag_o (cause_flag)
    );

    twd_fsm #(.INTERVAL_N(INTERVAL_N)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_any_i     (en_any),
        .service_i    (service),
        .state_o      (state),
        .first_exp_o  (first_exp),
        .second_exp_o (second_exp),
        .sys_rst_o    (sys_rst_o)
    );

    assign irq_o = warn_flag && en_any;
endmodule

// File: rtl/twd_checker.sv
module twd_checker #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned REG_W  = 32,
    parameter int unsigned TB_W   = 32,
    parameter bit          ONCE   = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              irq_o,
    input logic              sys_rst_o,
    input logic              en_any,
    input logic              cause_flag,
    input logic [TB_W-1:0]   tb_count
);
    logic svc_wr;
    assign svc_wr = bus_wr_en && (bus_addr[3:2] == 2'd0) && (bus_wdata[2] || bus_wdata[3]);

    AST_RESET_AFTER_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> $past(irq_o))
        else $error("reset without prior warning"); // R6

    AST_CAUSE_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        sys_rst_o |-> cause_flag)
        else $error("reset request without cause flag"); // R6

    AST_SERVICE_BLOCKS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        svc_wr |=> !sys_rst_o)
        else $error("reset after service"); // R7

    AST_DISARM_DROPS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_any) |=> !sys_rst_o)
        else $error("reset persists after disarm"); // R4

    AST_TIMEBASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tb_count == $past(tb_count) + TB_W'(1)))
        else $error("timebase skipped"); // R3

    AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((ONCE != 1'b0) && $past(rst_n) && $past(en_any)) |-> en_any)
        else $error("sticky enable dropped"); // R10
endmodule

bind twd_watchdog twd_checker #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .TB_W   (TB_W),
    .ONCE   (ENABLE_ONCE)
) u_twd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_n      (por_n),
    .bus_wr_en  (bus_wr_en),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .irq_o      (irq_o),
    .sys_rst_o  (sys_rst_o),
    .en_any     (en_any),
    .cause_flag (cause_flag),
    .tb_count   (tb_count)
);

// File: tb/test_twd_watchdog.sv
module test_twd_watchdog;
    localparam int N = 4;
    localparam int P = 1 << N;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata1;
    logic        irq, srst, irq1, srst1;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    twd_watchdog #(.INTERVAL_N(N), .ENABLE_ONCE(1'b0)) i_twd_watchdog (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .sys_rst_o(srst)
    );

    twd_watchdog #(.INTERVAL_N(N), .ENABLE_ONCE(1'b1)) i_twd_watchdog_once (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata1), .irq_o(irq1), .sys_rst_o(srst1)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (edge %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, output int e);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        e = cyc;
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] v, output logic [31:0] v1,
                          output int e);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        v = rdata; v1 = rdata1; e = cyc;
        rd_en = 1'b0;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic pulse_rst(input bit with_por);
        @(negedge clk);
        rst_n = 1'b0;
        if (with_por) por_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired at edge %0d", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int e, e2, e3, s;
        logic [31:0] v, v1, t1, t2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;

        // R1 reset state
        check("R1 irq after reset", {31'b0, irq}, 32'd0);
        check("R1 sys_rst after reset", {31'b0, srst}, 32'd0);
        bus_rd(4'h0, v, v1, e); check("R1 word 0x0", v, 32'h0);
        bus_rd(4'h4, v, v1, e); check("R1 word 0x4", v, 32'h0);
        bus_rd(4'hC, v, v1, e); check("R2 word 0xC reads zero", v, 32'h0);

        // R3 timebase spacing while disarmed
        bus_rd(4'h8, t1, v1, e);
        bus_rd(4'h8, t2, v1, e2);
        check("R3 timebase step", t2 - t1, 32'(e2 - e));
        repeat (7) @(negedge clk);
        bus_rd(4'h8, t1, v1, e3);
        check("R3 timebase gap", t1 - t2, 32'(e3 - e2));

        // R5/R6 basic expiry via enable A
        bus_wr(4'h0, 32'h2, e);
        bus_rd(4'h0, v, v1, e2); check("R2 enable A at bit 1", v, 32'h2);
        bus_rd(4'h4, v, v1, e2); check("R2 enable B clear", v, 32'h0);
        wait_until(e + P);     check("R5 no irq before window", {31'b0, irq}, 32'd0);
        wait_until(e + 1 + P); check("R5 irq at window end", {31'b0, irq}, 32'd1);
        bus_rd(4'h0, v, v1, e2); check("R2 warn flag at bit 2", v, 32'h6);
        wait_until(e + 2 * P);     check("R6 no reset before second window", {31'b0, srst}, 32'd0);
        wait_until(e + 1 + 2 * P); check("R6 reset at second window", {31'b0, srst}, 32'd1);
        bus_rd(4'h0, v, v1, e2); check("R2 cause flag at bit 3", v, 32'hE);
        repeat (10) @(negedge clk);
        check("R6 reset held", {31'b0, srst}, 32'd1);

        // R9 cause survives rst_n; R7 per-bit clearing
        pulse_rst(1'b0);
        check("R9 reset output cleared by rst_n", {31'b0, srst}, 32'd0);
        bus_rd(4'h0, v, v1, e); check("R9 cause kept over rst_n", v, 32'h8);
        bus_wr(4'h0, 32'h4, e);
        bus_rd(4'h0, v, v1, e); check("R7 bit 2 write leaves cause", v, 32'h8);
        bus_wr(4'h0, 32'h8, e);
        bus_rd(4'h0, v, v1, e); check("R7 bit 3 write clears cause", v, 32'h0);

        // R4 either enable suffices; R8 gating
        bus_wr(4'h4, 32'h1, e);
        bus_rd(4'h4, v, v1, e2); check("R2 enable B at bit 0", v, 32'h1);
        bus_wr(4'h0, 32'h0, e2);
        wait_until(e + P);     check("R4 one bit clear, no early irq", {31'b0, irq}, 32'd0);
        wait_until(e + 1 + P); check("R4 enable B alone runs", {31'b0, irq}, 32'd1);
        bus_wr(4'h4, 32'h0, e2);
        check("R8 irq drops on disarm", {31'b0, irq}, 32'd0);
        bus_rd(4'h0, v, v1, e3); check("R8 flag still readable", v, 32'h4);
        repeat (3 * P) @(negedge clk);
        check("R4 disarmed, no reset", {31'b0, srst}, 32'd0);

        // R11 disarm clears count
        bus_wr(4'h0, 32'h4, e);
        bus_wr(4'h4, 32'h1, e);
        wait_until(e + P / 2);
        bus_wr(4'h4, 32'h0, e2);
        bus_wr(4'h4, 32'h1, e3);
        wait_until(e3 + P);     check("R11 full window after re-arm", {31'b0, irq}, 32'd0);
        wait_until(e3 + 1 + P); check("R11 irq after re-arm window", {31'b0, irq}, 32'd1);

        // R7 sweep of service phase over both windows
        for (int k = 0; k < 2 * P; k++) begin
            bus_wr(4'h0, 32'hC, e);
            bus_wr(4'h4, 32'h0, e);
            bus_wr(4'h4, 32'h1, e);
            wait_until(e + k);
            check($sformatf("R5 irq before service k=%0d", k), {31'b0, irq},
                  (k >= 1 + P) ? 32'd1 : 32'd0);
            check($sformatf("R6 no reset before service k=%0d", k), {31'b0, srst}, 32'd0);
            bus_wr(4'h0, 32'hC, s);
            check($sformatf("R7 service clears irq k=%0d", k), {31'b0, irq}, 32'd0);
            check($sformatf("R7 service wins over expiry k=%0d", k), {31'b0, srst}, 32'd0);
            wait_until(s + P - 1);
            check($sformatf("R7 window restarted k=%0d", k), {31'b0, irq}, 32'd0);
            wait_until(s + P);
            check($sformatf("R7 irq after restarted window k=%0d", k), {31'b0, irq}, 32'd1);
        end

        // R10 sticky enable instance against plain instance
        pulse_rst(1'b1);
        bus_wr(4'h4, 32'h1, e);
        bus_wr(4'h4, 32'h0, e2);
        bus_wr(4'h0, 32'h0, e2);
        bus_rd(4'h4, v, v1, e2);
        check("R10 sticky enable B still set", v1, 32'h1);
        check("R4 plain enable B cleared", v, 32'h0);
        wait_until(e + 1 + P);
        check("R10 sticky instance warns", {31'b0, irq1}, 32'd1);
        check("R4 plain instance stopped", {31'b0, irq}, 32'd0);
        wait_until(e + 1 + 2 * P);
        check("R10 sticky instance resets", {31'b0, srst1}, 32'd1);
        check("R4 plain instance no reset", {31'b0, srst}, 32'd0);

        // R9 power-on reset clears cause
        pulse_rst(1'b1);
        bus_wr(4'h4, 32'h1, e);
        wait_until(e + 1 + 2 * P);
        check("R6 reset fired for power-on test", {31'b0, srst}, 32'd1);
        pulse_rst(1'b1);
        bus_rd(4'h0, v, v1, e); check("R9 power-on reset clears cause", v, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule